// File: doc/BRIEF.md
# Host Transfer Address Generator

This block produces the byte addresses for a transfer of decoded data between buffer storage and a host port. Firmware writes a 21-bit start address into three byte-wide registers and a 16-bit byte count into two more. It then writes to a trigger register to start the transfer. The highest address register also carries a routing bit. That bit sends the whole transfer either to a small on-chip memory or to the external buffer.

While a transfer runs, each byte strobe from the host side issues one memory request at the current address. The address then steps up by one and the count steps down by one. When the count is used up, the block goes idle and raises an end-of-transfer interrupt. Firmware clears the interrupt by writing to an acknowledge register. The data written to the trigger and acknowledge registers is discarded.

On-chip memory must not be touched while error correction is running. A byte strobe aimed at on-chip memory during that time is held off and recorded in an error flag. The address is not promised to be meaningful once a transfer ends, so firmware reloads it before every transfer. A typical reload copies the head pointer of a corrected block, which sends that block to the host.

Top module: `xfer_addr_gen`

## Requirements
- R1: After reset, busy, xfer_irq, xfer_err, mem_int and mem_req are 0 and mem_addr is 0.
- R2: While idle, a write to register select 0, 1 or 2 loads mem_addr[7:0], mem_addr[15:8] or mem_addr[20:16] respectively. Select 2 supplies its bits 4:0. The new value shows on mem_addr from the next cycle.
- R3: Bit 7 of a select-2 write chooses the memory: 1 drives mem_int high (on-chip memory) and 0 drives it low (external buffer), from the next cycle.
- R4: While idle, selects 3 and 4 load the low and high bytes of the byte count. A write to select 5 with any data and a nonzero count sets busy from the next cycle, and mem_addr still holds the loaded start address.
- R5: While busy and not blocked, byte_stb drives mem_req high in the same cycle. In the next cycle mem_addr has risen by one, with the carry passing across byte boundaries. With no strobe, mem_addr holds.
- R6: On the clock edge that takes the last counted byte, busy falls and xfer_irq rises together.
- R7: A write to select 6 with any data clears xfer_irq from the next cycle. If the end of a transfer falls on the same edge, xfer_irq is set instead.
- R8: While busy, writes to selects 0 to 5 are ignored. The address, the memory choice, the count and the transfer in progress are left unchanged.
- R9: A trigger write while idle with a count of 0 leaves busy low and sets xfer_irq from the next cycle.
- R10: While busy with mem_int high and ecc_busy high, a byte strobe does not raise mem_req. It leaves the address and count unchanged and sets xfer_err from the next cycle. xfer_err stays set until the next accepted trigger clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0-2 address bytes, 3-4 count bytes, 5 trigger, 6 acknowledge |
| reg_wdata | input | 8 | Register write data |
| byte_stb | input | 1 | One byte moved this cycle |
| ecc_busy | input | 1 | Error correction is using on-chip memory |
| mem_addr | output | 21 | Current transfer address |
| mem_int | output | 1 | 1 = on-chip memory, 0 = external buffer |
| mem_req | output | 1 | Memory access issued this cycle |
| busy | output | 1 | Transfer active |
| xfer_irq | output | 1 | End-of-transfer interrupt flag |
| xfer_err | output | 1 | On-chip access was blocked during error correction |

## Verification
Two situations are hard to reach from the ports. The first is a byte strobe aimed at on-chip memory while error correction holds it. The bench gets there by routing a transfer on-chip, raising ecc_busy and strobing, then checking that the count was truly frozen. It does so by counting the strobes needed to finish. The second is an acknowledge write on the very edge that finishes a transfer. The bench drives the acknowledge write and the final byte strobe in the same cycle, using a one-byte transfer.

// File: rtl/xag_pkg.sv
package xag_pkg;

    localparam int REG_SEL_W   = 3;
    localparam int NUM_REGS    = 7;
    localparam int MEM_SEL_BIT = 7;

    typedef enum logic [REG_SEL_W-1:0] {
        REG_ADDR0 = 3'd0,
        REG_ADDR1 = 3'd1,
        REG_ADDR2 = 3'd2,
        REG_LEN0  = 3'd3,
        REG_LEN1  = 3'd4,
        REG_TRIG  = 3'd5,
        REG_ACK   = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic active;
        logic mem_int;
        logic irq;
        logic err;
    } ctrl_state_t;

endpackage

// File: rtl/xag_decode.sv
module xag_decode
    import xag_pkg::*;
(
    input  logic                 we,
    input  logic [REG_SEL_W-1:0] sel,
    output logic [NUM_REGS-1:0]  strb
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_strb
        assign strb[i] = we && (sel == REG_SEL_W'(i));
    end

endmodule

// File: rtl/xag_lane_cnt.sv
module xag_lane_cnt #(
    parameter int W  = 21,
    parameter int UP = 1,
    localparam int NL = (W + 7) / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] lane_we,
    input  logic [7:0]    wdata,
    input  logic          step,
    output logic [W-1:0]  value
);

    logic [W-1:0] val_d, val_q;
    logic [W-1:0] merged;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam int LW = (i == NL - 1) ? (W - 8 * i) : 8;
        assign merged[8*i +: LW] = lane_we[i] ? wdata[LW-1:0] : val_q[8*i +: LW];
    end

    always_comb begin
        val_d = merged;
        if (step) begin
            if (UP != 0) val_d = val_q + W'(1);
            else         val_d = val_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;

endmodule

// File: rtl/xag_ctrl.sv
module xag_ctrl
    import xag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_wr,
    input  logic hi_bit,
    input  logic trig_wr,
    input  logic ack_wr,
    input  logic byte_stb,
    input  logic ecc_busy,
    input  logic len_zero,
    input  logic len_one,
    output logic active,
    output logic mem_int,
    output logic irq,
    output logic err,
    output logic step
);

    ctrl_state_t s_d, s_q;
    logic blocked, last, start, zero_start;

    always_comb begin
        s_d        = s_q;
        blocked    = s_q.mem_int & ecc_busy;
        step       = s_q.active & byte_stb & ~blocked;
        last       = step & len_one;
        start      = trig_wr & ~s_q.active & ~len_zero;
        zero_start = trig_wr & ~s_q.active & len_zero;

        if (hi_wr && !s_q.active) s_d.mem_int = hi_bit;

        if (start) begin
            s_d.active = 1'b1;
            s_d.err    = 1'b0;
        end else if (last) begin
            s_d.active = 1'b0;
        end
        if (zero_start) s_d.err = 1'b0;

        if (ack_wr) s_d.irq = 1'b0;
        if (last || zero_start) s_d.irq = 1'b1;

        if (s_q.active && byte_stb && blocked) s_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.active;
    assign mem_int = s_q.mem_int;
    assign irq     = s_q.irq;
    assign err     = s_q.err;

endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
    import xag_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int LEN_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_SEL_W-1:0] reg_sel,
    input  logic [7:0]           reg_wdata,
    input  logic                 byte_stb,
    input  logic                 ecc_busy,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_int,
    output logic                 mem_req,
    output logic                 busy,
    output logic                 xfer_irq,
    output logic                 xfer_err
);

    localparam int ADDR_LANES = (ADDR_W + 7) / 8;
    localparam int LEN_LANES  = (LEN_W + 7) / 8;

    logic [NUM_REGS-1:0]   wr;
    logic [ADDR_LANES-1:0] addr_we;
    logic [LEN_LANES-1:0]  len_we;
    logic [LEN_W-1:0]      len;
    logic                  idle, step;

    xag_decode u_dec (.we(reg_we), .sel(reg_sel), .strb(wr));

    assign idle = ~busy;

    for (genvar i = 0; i < ADDR_LANES; i++) begin : g_awe
        assign addr_we[i] = wr[int'(REG_ADDR0) + i] & idle;
    end
    for (genvar i = 0; i < LEN_LANES; i++) begin : g_lwe
        assign len_we[i] = wr[int'(REG_LEN0) + i] & idle;
    end

    xag_lane_cnt #(.W(ADDR_W), .UP(1)) u_addr (
        .clk(clk), .rst_n(rst_n), .lane_we(addr_we), .wdata(reg_wdata),
        .step(step), .value(mem_addr)
    );

    xag_lane_cnt #(.W(LEN_W), .UP(0)) u_len (
        .clk(clk), .rst_n(rst_n), .lane_we(len_we), .wdata(reg_wdata),
        .step(step), .value(len)
    );

    xag_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .hi_wr(wr[REG_ADDR2]), .hi_bit(reg_wdata[MEM_SEL_BIT]),
        .trig_wr(wr[REG_TRIG]), .ack_wr(wr[REG_ACK]),
        .byte_stb(byte_stb), .ecc_busy(ecc_busy),
        .len_zero(len == '0), .len_one(len == LEN_W'(1)),
        .active(busy), .mem_int(mem_int), .irq(xfer_irq), .err(xfer_err),
        .step(step)
    );

    assign mem_req = step;

endmodule

// File: rtl/xfer_addr_gen_chk.sv
module xfer_addr_gen_chk
    import xag_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [REG_SEL_W-1:0] reg_sel,
    input logic                 byte_stb,
    input logic                 ecc_busy,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_int,
    input logic                 mem_req,
    input logic                 busy,
    input logic                 xfer_irq,
    input logic                 xfer_err
);

    // R5
    step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R5
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy && byte_stb);

    // R8
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_req |=> $stable(mem_addr) && $stable(mem_int));

    // R8
    trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_req && reg_we && reg_sel == REG_TRIG |=> busy);

    // R10
    block_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && byte_stb && mem_int && ecc_busy |-> !mem_req);

    // R10
    block_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && byte_stb && mem_int && ecc_busy |=> xfer_err);

    // R6
    end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> xfer_irq);

endmodule

bind xfer_addr_gen xfer_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xfer_addr_gen_test.sv
module xfer_addr_gen_test;
    import xag_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        byte_stb = 1'b0;
    logic        ecc_busy = 1'b0;
    logic [20:0] mem_addr;
    logic        mem_int, mem_req, busy, xfer_irq, xfer_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xfer_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .byte_stb(byte_stb), .ecc_busy(ecc_busy),
        .mem_addr(mem_addr), .mem_int(mem_int), .mem_req(mem_req),
        .busy(busy), .xfer_irq(xfer_irq), .xfer_err(xfer_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic stb(input logic exp_req, input string tag);
        @(negedge clk);
        byte_stb = 1'b1;
        #1 chk(tag, mem_req, exp_req);
        @(negedge clk);
        byte_stb = 1'b0;
    endtask

    task automatic load(input logic [23:0] a, input logic [15:0] n);
        wr(REG_ADDR0, a[7:0]);
        wr(REG_ADDR1, a[15:8]);
        wr(REG_ADDR2, a[23:16]);
        wr(REG_LEN0, n[7:0]);
        wr(REG_LEN1, n[15:8]);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 irq", xfer_irq, 0);
        chk("R1 err", xfer_err, 0);
        chk("R1 mem_int", mem_int, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 addr", mem_addr, 0);
    endtask

    task automatic t_load();
        wr(REG_ADDR0, 8'h12);
        chk("R2 low byte", mem_addr, 21'h000012);
        wr(REG_ADDR1, 8'h34);
        wr(REG_ADDR2, 8'h85);
        chk("R2 full addr", mem_addr, 21'h053412);
        chk("R3 internal", mem_int, 1);
        wr(REG_ADDR2, 8'h05);
        chk("R3 external", mem_int, 0);
    endtask

    task automatic t_basic();
        load(24'h00FFFE, 16'd3);
        wr(REG_TRIG, 8'hA5);
        chk("R4 busy", busy, 1);
        chk("R4 start addr", mem_addr, 21'h00FFFE);
        stb(1, "R5 req 1");
        chk("R5 addr 1", mem_addr, 21'h00FFFF);
        @(negedge clk);
        chk("R5 hold idle strobe", mem_addr, 21'h00FFFF);
        stb(1, "R5 req 2");
        chk("R5 carry", mem_addr, 21'h010000);
        chk("R6 still busy", busy, 1);
        chk("R6 no irq yet", xfer_irq, 0);
        stb(1, "R5 req 3");
        chk("R6 busy falls", busy, 0);
        chk("R6 irq set", xfer_irq, 1);
        wr(REG_ACK, 8'h3C);
        chk("R7 irq cleared", xfer_irq, 0);
        stb(0, "R5 no req idle");
    endtask

    task automatic t_busy_ignore();
        load(24'h000100, 16'd2);
        wr(REG_TRIG, 8'h00);
        wr(REG_ADDR0, 8'hAA);
        chk("R8 addr write ignored", mem_addr, 21'h000100);
        wr(REG_ADDR2, 8'h80);
        chk("R8 mem select ignored", mem_int, 0);
        wr(REG_LEN1, 8'h55);
        wr(REG_TRIG, 8'hFF);
        chk("R8 still busy", busy, 1);
        chk("R8 addr after trig", mem_addr, 21'h000100);
        stb(1, "R8 req 1");
        stb(1, "R8 req 2");
        chk("R8 count unchanged", busy, 0);
        chk("R8 end addr", mem_addr, 21'h000102);
        wr(REG_ACK, 8'h00);
    endtask

    task automatic t_zero();
        load(24'h000200, 16'd0);
        wr(REG_TRIG, 8'h11);
        chk("R9 not busy", busy, 0);
        chk("R9 irq", xfer_irq, 1);
        wr(REG_ACK, 8'h99);
        chk("R7 irq cleared zero", xfer_irq, 0);
    endtask

    task automatic t_block();
        load(24'h800010, 16'd2);
        chk("R3 internal sel", mem_int, 1);
        wr(REG_TRIG, 8'h01);
        ecc_busy = 1'b1;
        stb(0, "R10 blocked req");
        chk("R10 addr held", mem_addr, 21'h000010);
        chk("R10 err", xfer_err, 1);
        chk("R10 busy", busy, 1);
        ecc_busy = 1'b0;
        stb(1, "R10 req after");
        chk("R10 count held", busy, 1);
        stb(1, "R10 req last");
        chk("R10 done", busy, 0);
        chk("R10 err sticky", xfer_err, 1);
        wr(REG_ACK, 8'h00);
        chk("R10 err kept by ack", xfer_err, 1);
        load(24'h000020, 16'd1);
        wr(REG_TRIG, 8'h00);
        chk("R10 err cleared", xfer_err, 0);
        stb(1, "R10 ext req");
        wr(REG_ACK, 8'h00);
    endtask

    task automatic t_collide();
        load(24'h000300, 16'd1);
        wr(REG_TRIG, 8'h00);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = REG_ACK; reg_wdata = 8'h00; byte_stb = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; byte_stb = 1'b0;
        chk("R7 set wins", xfer_irq, 1);
        chk("R6 done collide", busy, 0);
        wr(REG_ACK, 8'h00);
        chk("R7 clear after", xfer_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_basic();
        t_busy_ignore();
        t_zero();
        t_block();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule